// File: doc/BRIEF.md
# USB Control Endpoint Handshake Responder

This block keeps the state of one control endpoint of a full-speed USB device and picks the reply the device gives in each transaction. A token decoder supplies the token kind. A receive path reports the end of a data packet together with its byte count, CRC verdict and the toggle it carried. The transmit path is told when to send data and which toggle to use. It then reports the host's ACK. Firmware reads and writes one register word. That word holds the direction status fields, the two data toggles, a status-stage kind bit and the completion flags.

Each transaction moves through a small machine. Its states are IDLE, RX_WAIT (a data packet is expected after OUT or SETUP), TX_SEND (a one-cycle request to send data), TX_WAIT (waiting for the host's ACK) and REPLY (a one-cycle handshake pulse). The transitions are:

- IDLE→RX_WAIT on an OUT or SETUP token.
- IDLE→TX_SEND on an IN token when the transmit status is VALID.
- IDLE→REPLY on an IN token when the transmit status is NAK or STALL.
- RX_WAIT→REPLY when the verdict on the finished packet is to answer. RX_WAIT→IDLE when it is to stay silent.
- TX_SEND→TX_WAIT unconditionally.
- TX_WAIT→IDLE on the host ACK.
- REPLY→IDLE unconditionally.

In any state except REPLY, a fresh token restarts the machine.

A SETUP is never refused. It is accepted whatever the receive status. The one exception is when firmware has not yet cleared the flag of an earlier reception. In that case the packet is dropped in silence, so the host retries.

Top module: `ctl_ep_responder`

## Requirements
- R1: Register word layout: [1:0] transmit status, [3:2] receive status, [4] transmit toggle, [5] receive toggle, [6] status-out kind, [7] transmit-complete, [8] receive-complete, [9] SETUP-seen (read-only). Status codes are 00 disabled, 01 stall, 10 nak, 11 valid. Reset clears the whole word. Token codes on `tok_kind` are 00 OUT, 01 IN, 10 SETUP.
- R2: A good SETUP while receive-complete is clear gets ACK whatever the receive status. It sets the transmit toggle to 1 and the receive toggle to 0, puts both statuses at nak, and sets receive-complete and SETUP-seen.
- R3: A SETUP that arrives while receive-complete is still set gets no handshake and changes no register.
- R4: An OUT with receive status nak or stall gets that handshake (code 01 nak, 10 stall; 00 is ACK). A disabled receive direction gives no handshake. Neither case changes any register. The handshake pulse comes one cycle after the end of the packet.
- R5: An OUT with valid status whose toggle matches the receive toggle gets ACK. It flips the receive toggle, sets receive-complete, clears SETUP-seen and sets the receive status to nak.
- R6: An OUT with valid status and a toggle mismatch gets ACK and changes nothing.
- R7: With status-out kind set, a valid OUT that carries one or more bytes gets STALL and sets no flag. A zero-length one is handled as in R5.
- R8: An IN with valid transmit status raises `send_data` for exactly one cycle, one cycle after the token, while `tx_toggle` shows the transmit toggle. The host ACK then flips the transmit toggle, sets transmit-complete and sets the transmit status to nak.
- R9: An IN with transmit status nak or stall gets that handshake and never ACK. A disabled transmit direction gives no handshake.
- R10: A packet with a bad CRC gets no handshake and changes no register.
- R11: A completion flag is cleared only by writing 0 to its bit. Writing 1 leaves it as it is. SETUP-seen ignores writes.
- R12: When hardware updates a field in the same cycle that software writes it, the hardware value wins.
- R13: `irq` is high exactly while either completion flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_valid | input | 1 | One-cycle token strobe |
| tok_kind | input | 2 | Token kind (R1 codes) |
| rx_done | input | 1 | End of a received data packet |
| rx_count | input | CNT_W | Byte count of that packet |
| rx_crc_ok | input | 1 | CRC of that packet is good |
| rx_toggle | input | 1 | Data toggle the packet carried |
| host_ack | input | 1 | Host acknowledged the sent data |
| sw_we | input | 1 | Register write strobe |
| sw_wdata | input | 10 | Register write value |
| sw_rdata | output | 10 | Register read value |
| hs_valid | output | 1 | Handshake pulse |
| hs_code | output | 2 | Handshake kind |
| send_data | output | 1 | Request to transmit a data packet |
| tx_toggle | output | 1 | Toggle for the outgoing packet |
| irq | output | 1 | A completion flag is set |

## Verification
The checker assumes that the token decoder does not send a new token while a handshake pulse is being emitted. It also assumes that `rx_done` comes only while a data packet is expected, and `host_ack` only after data was requested. The bench follows this. Each transaction task waits until the machine is back in IDLE before it starts the next token. The same-cycle software write is always placed on the edge where the reception finishes.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;

    typedef enum logic [1:0] {
        ST_DISABLED = 2'b00,
        ST_STALL    = 2'b01,
        ST_NAK      = 2'b10,
        ST_VALID    = 2'b11
    } ep_stat_e;

    typedef enum logic [1:0] {
        TK_OUT   = 2'b00,
        TK_IN    = 2'b01,
        TK_SETUP = 2'b10
    } tok_kind_e;

    typedef enum logic [1:0] {
        HS_ACK   = 2'b00,
        HS_NAK   = 2'b01,
        HS_STALL = 2'b10
    } hs_code_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX_WAIT,
        S_TX_SEND,
        S_TX_WAIT,
        S_REPLY
    } xact_state_e;

    // direction index: 0 transmit, 1 receive
    localparam int NUM_DIR  = 2;
    localparam int STAT_W   = 2;
    localparam int TOG_LSB  = NUM_DIR * STAT_W;
    localparam int KIND_BIT = TOG_LSB + NUM_DIR;
    localparam int CPL_LSB  = KIND_BIT + 1;
    localparam int SEEN_BIT = CPL_LSB + NUM_DIR;
    localparam int REG_W    = SEEN_BIT + 1;

    typedef struct packed {
        logic     setup_seen;
        logic     rx_cpl;
        logic     tx_cpl;
        logic     stat_out;
        logic     rx_tog;
        logic     tx_tog;
        ep_stat_e rx_stat;
        ep_stat_e tx_stat;
    } ep_view_t;

    typedef struct packed {
        logic     wr_tx_stat;
        ep_stat_e tx_stat;
        logic     wr_rx_stat;
        ep_stat_e rx_stat;
        logic     wr_tx_tog;
        logic     tx_tog;
        logic     wr_rx_tog;
        logic     rx_tog;
        logic     set_tx_cpl;
        logic     set_rx_cpl;
        logic     wr_seen;
        logic     seen_val;
    } hw_upd_t;

endpackage

// File: rtl/ctl_ep_regs.sv
module ctl_ep_regs
    import ctl_ep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_we,
    input  logic [REG_W-1:0] sw_wdata,
    input  hw_upd_t          upd,
    output ep_view_t         view
);

    logic [NUM_DIR*STAT_W-1:0] stat_bus;
    logic [NUM_DIR-1:0]        tog_bus;
    logic [NUM_DIR-1:0]        cpl_bus;
    logic [NUM_DIR-1:0]        hw_st_wr;
    logic [NUM_DIR*STAT_W-1:0] hw_st_val;
    logic [NUM_DIR-1:0]        hw_tog_wr;
    logic [NUM_DIR-1:0]        hw_tog_val;
    logic [NUM_DIR-1:0]        hw_cpl_set;
    logic                      kind_q;
    logic                      seen_q;
    logic                      unused_seen_wr;

    assign hw_st_wr   = {upd.wr_rx_stat, upd.wr_tx_stat};
    assign hw_st_val  = {upd.rx_stat, upd.tx_stat};
    assign hw_tog_wr  = {upd.wr_rx_tog, upd.wr_tx_tog};
    assign hw_tog_val = {upd.rx_tog, upd.tx_tog};
    assign hw_cpl_set = {upd.set_rx_cpl, upd.set_tx_cpl};
    assign unused_seen_wr = sw_wdata[SEEN_BIT];

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        logic [STAT_W-1:0] st_r;
        logic              tog_r;
        logic              cpl_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_r  <= '0;
                tog_r <= 1'b0;
                cpl_r <= 1'b0;
            end else begin
                // hardware update outranks a same-cycle software write
                if (hw_st_wr[d])
                    st_r <= hw_st_val[d*STAT_W +: STAT_W];
                else if (sw_we)
                    st_r <= sw_wdata[d*STAT_W +: STAT_W];

                if (hw_tog_wr[d])
                    tog_r <= hw_tog_val[d];
                else if (sw_we)
                    tog_r <= sw_wdata[TOG_LSB + d];

                if (hw_cpl_set[d])
                    cpl_r <= 1'b1;
                else if (sw_we && !sw_wdata[CPL_LSB + d])
                    cpl_r <= 1'b0;
            end
        end

        assign stat_bus[d*STAT_W +: STAT_W] = st_r;
        assign tog_bus[d] = tog_r;
        assign cpl_bus[d] = cpl_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            if (sw_we)
                kind_q <= sw_wdata[KIND_BIT];
            if (upd.wr_seen)
                seen_q <= upd.seen_val;
        end
    end

    always_comb begin
        view.tx_stat    = ep_stat_e'(stat_bus[0 +: STAT_W]);
        view.rx_stat    = ep_stat_e'(stat_bus[STAT_W +: STAT_W]);
        view.tx_tog     = tog_bus[0];
        view.rx_tog     = tog_bus[1];
        view.stat_out   = kind_q;
        view.tx_cpl     = cpl_bus[0];
        view.rx_cpl     = cpl_bus[1];
        view.setup_seen = seen_q;
    end

endmodule

// File: rtl/ctl_ep_rx_judge.sv
module ctl_ep_rx_judge
    import ctl_ep_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  tok_kind_e        kind,
    input  ep_stat_e         rx_stat,
    input  logic             rx_tog,
    input  logic             rx_cpl,
    input  logic             stat_out,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_crc_ok,
    input  logic             rx_toggle,
    output logic             respond,
    output hs_code_e         code,
    output hw_upd_t          upd
);

    always_comb begin
        respond = 1'b0;
        code    = HS_ACK;
        upd     = '0;
        if (rx_crc_ok) begin
            if (kind == TK_SETUP) begin
                if (!rx_cpl) begin
                    respond        = 1'b1;
                    upd.wr_tx_tog  = 1'b1;
                    upd.tx_tog     = 1'b1;
                    upd.wr_rx_tog  = 1'b1;
                    upd.rx_tog     = 1'b0;
                    upd.wr_tx_stat = 1'b1;
                    upd.tx_stat    = ST_NAK;
                    upd.wr_rx_stat = 1'b1;
                    upd.rx_stat    = ST_NAK;
                    upd.set_rx_cpl = 1'b1;
                    upd.wr_seen    = 1'b1;
                    upd.seen_val   = 1'b1;
                end
            end else begin
                unique case (rx_stat)
                    ST_STALL: begin
                        respond = 1'b1;
                        code    = HS_STALL;
                    end
                    ST_NAK: begin
                        respond = 1'b1;
                        code    = HS_NAK;
                    end
                    ST_VALID: begin
                        respond = 1'b1;
                        if (stat_out && (rx_count != '0)) begin
                            code = HS_STALL;
                        end else if (rx_toggle == rx_tog) begin
                            upd.wr_rx_tog  = 1'b1;
                            upd.rx_tog     = ~rx_tog;
                            upd.set_rx_cpl = 1'b1;
                            upd.wr_seen    = 1'b1;
                            upd.seen_val   = 1'b0;
                            upd.wr_rx_stat = 1'b1;
                            upd.rx_stat    = ST_NAK;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/ctl_ep_fsm.sv
module ctl_ep_fsm
    import ctl_ep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tok_valid,
    input  logic [1:0] tok_kind,
    input  logic       rx_done,
    input  logic       host_ack,
    input  ep_stat_e   tx_stat,
    input  logic       tx_tog,
    input  logic       rx_respond,
    input  hs_code_e   rx_code,
    input  hw_upd_t    rx_upd,
    output logic       hs_valid,
    output hs_code_e   hs_code,
    output logic       send_data,
    output hw_upd_t    upd,
    output tok_kind_e  kind_q
);

    xact_state_e state, nxt;
    hs_code_e    code_q, nxt_code;
    tok_kind_e   nxt_kind;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            code_q <= HS_ACK;
            kind_q <= TK_OUT;
        end else begin
            state  <= nxt;
            code_q <= nxt_code;
            kind_q <= nxt_kind;
        end
    end

    always_comb begin
        nxt      = state;
        nxt_code = code_q;
        nxt_kind = kind_q;
        upd      = '0;
        if (tok_valid && state != S_REPLY) begin
            unique case (tok_kind)
                TK_OUT: begin
                    nxt_kind = TK_OUT;
                    nxt      = S_RX_WAIT;
                end
                TK_SETUP: begin
                    nxt_kind = TK_SETUP;
                    nxt      = S_RX_WAIT;
                end
                TK_IN: begin
                    nxt_kind = TK_IN;
                    unique case (tx_stat)
                        ST_VALID: nxt = S_TX_SEND;
                        ST_NAK: begin
                            nxt      = S_REPLY;
                            nxt_code = HS_NAK;
                        end
                        ST_STALL: begin
                            nxt      = S_REPLY;
                            nxt_code = HS_STALL;
                        end
                        default: nxt = S_IDLE;
                    endcase
                end
                default: nxt = S_IDLE;
            endcase
        end else begin
            unique case (state)
                S_IDLE: ;
                S_RX_WAIT: begin
                    if (rx_done) begin
                        upd      = rx_upd;
                        nxt_code = rx_code;
                        nxt      = rx_respond ? S_REPLY : S_IDLE;
                    end
                end
                S_TX_SEND: nxt = S_TX_WAIT;
                S_TX_WAIT: begin
                    if (host_ack) begin
                        upd.wr_tx_tog  = 1'b1;
                        upd.tx_tog     = ~tx_tog;
                        upd.set_tx_cpl = 1'b1;
                        upd.wr_tx_stat = 1'b1;
                        upd.tx_stat    = ST_NAK;
                        nxt            = S_IDLE;
                    end
                end
                S_REPLY: nxt = S_IDLE;
                default: nxt = S_IDLE;
            endcase
        end
    end

    always_comb begin
        hs_valid  = (state == S_REPLY);
        hs_code   = code_q;
        send_data = (state == S_TX_SEND);
    end

endmodule

// File: rtl/ctl_ep_responder.sv
module ctl_ep_responder
    import ctl_ep_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_valid,
    input  logic [1:0]       tok_kind,
    input  logic             rx_done,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_crc_ok,
    input  logic             rx_toggle,
    input  logic             host_ack,
    input  logic             sw_we,
    input  logic [REG_W-1:0] sw_wdata,
    output logic [REG_W-1:0] sw_rdata,
    output logic             hs_valid,
    output logic [1:0]       hs_code,
    output logic             send_data,
    output logic             tx_toggle,
    output logic             irq
);

    ep_view_t  view;
    hw_upd_t   upd;
    hw_upd_t   rx_upd;
    tok_kind_e kind_q;
    hs_code_e  rx_code;
    hs_code_e  hs_code_e_w;
    logic      rx_respond;

    ctl_ep_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_we    (sw_we),
        .sw_wdata (sw_wdata),
        .upd      (upd),
        .view     (view)
    );

    ctl_ep_rx_judge #(.CNT_W(CNT_W)) u_judge (
        .kind      (kind_q),
        .rx_stat   (view.rx_stat),
        .rx_tog    (view.rx_tog),
        .rx_cpl    (view.rx_cpl),
        .stat_out  (view.stat_out),
        .rx_count  (rx_count),
        .rx_crc_ok (rx_crc_ok),
        .rx_toggle (rx_toggle),
        .respond   (rx_respond),
        .code      (rx_code),
        .upd       (rx_upd)
    );

    ctl_ep_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tok_valid  (tok_valid),
        .tok_kind   (tok_kind),
        .rx_done    (rx_done),
        .host_ack   (host_ack),
        .tx_stat    (view.tx_stat),
        .tx_tog     (view.tx_tog),
        .rx_respond (rx_respond),
        .rx_code    (rx_code),
        .rx_upd     (rx_upd),
        .hs_valid   (hs_valid),
        .hs_code    (hs_code_e_w),
        .send_data  (send_data),
        .upd        (upd),
        .kind_q     (kind_q)
    );

    assign hs_code   = hs_code_e_w;
    assign sw_rdata  = view;
    assign tx_toggle = view.tx_tog;
    assign irq       = view.tx_cpl | view.rx_cpl;

endmodule

// File: rtl/ctl_ep_responder_chk.sv
module ctl_ep_responder_chk
    import ctl_ep_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tok_valid,
    input logic       host_ack,
    input logic       sw_we,
    input logic       sw_rx_cpl_bit,
    input logic       hs_valid,
    input logic [1:0] hs_code,
    input logic       send_data,
    input logic [1:0] kind_q,
    input logic       tx_tog,
    input logic       rx_tog,
    input logic       tx_cpl,
    input logic       rx_cpl,
    input logic       setup_seen
);

    // R2: an answered SETUP is an ACK and leaves the control-transfer start state
    p_setup_acked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && kind_q == TK_SETUP) |->
            (hs_code == HS_ACK && tx_tog && !rx_tog && rx_cpl && setup_seen));

    // R7: a status-out STALL never raises the receive flag
    p_stall_no_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && kind_q == TK_OUT && hs_code == HS_STALL) |-> !$rose(rx_cpl));

    // R8: data request lasts one cycle
    p_send_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (send_data && !tok_valid) |=> !send_data);

    // R8: transmit flag rises only after a host ACK
    p_tx_flag_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_cpl) |-> $past(host_ack));

    // R9: an IN is never answered with an ACK handshake
    p_in_no_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && kind_q == TK_IN) |-> hs_code != HS_ACK);

    // R11: receive flag falls only on a software write of 0
    p_rx_flag_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_cpl) |-> ($past(sw_we) && !$past(sw_rx_cpl_bit)));

endmodule

bind ctl_ep_responder ctl_ep_responder_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tok_valid     (tok_valid),
    .host_ack      (host_ack),
    .sw_we         (sw_we),
    .sw_rx_cpl_bit (sw_wdata[ctl_ep_pkg::CPL_LSB + 1]),
    .hs_valid      (hs_valid),
    .hs_code       (hs_code),
    .send_data     (send_data),
    .kind_q        (kind_q),
    .tx_tog        (view.tx_tog),
    .rx_tog        (view.rx_tog),
    .tx_cpl        (view.tx_cpl),
    .rx_cpl        (view.rx_cpl),
    .setup_seen    (view.setup_seen)
);

// File: tb/ctl_ep_responder_test.sv
module ctl_ep_responder_test;

    localparam logic [1:0] DIS = 2'b00, STL = 2'b01, NAK = 2'b10, VAL = 2'b11;
    localparam logic [1:0] K_OUT = 2'b00, K_IN = 2'b01, K_SETUP = 2'b10;
    localparam int E_ACK = 0, E_NAK = 1, E_STALL = 2, E_SEND = 3, E_NONE = -1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tok_valid = 1'b0;
    logic [1:0] tok_kind = 2'b00;
    logic       rx_done = 1'b0;
    logic [6:0] rx_count = '0;
    logic       rx_crc_ok = 1'b0;
    logic       rx_toggle = 1'b0;
    logic       host_ack = 1'b0;
    logic       sw_we = 1'b0;
    logic [9:0] sw_wdata = '0;
    logic [9:0] sw_rdata;
    logic       hs_valid;
    logic [1:0] hs_code;
    logic       send_data;
    logic       tx_toggle;
    logic       irq;

    int    n_checks = 0;
    int    n_fail = 0;
    int    exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    ctl_ep_responder uut (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
        .rx_done(rx_done), .rx_count(rx_count), .rx_crc_ok(rx_crc_ok),
        .rx_toggle(rx_toggle), .host_ack(host_ack), .sw_we(sw_we),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .hs_valid(hs_valid),
        .hs_code(hs_code), .send_data(send_data), .tx_toggle(tx_toggle), .irq(irq)
    );

    function automatic logic [9:0] mk(input bit seen, input bit rc, input bit tc,
                                      input bit so, input bit rt, input bit tt,
                                      input logic [1:0] rs, input logic [1:0] ts);
        return {seen, rc, tc, so, rt, tt, rs, ts};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: every handshake or data request must match the next queued item
    always @(negedge clk) begin
        if (rst_n && (hs_valid || send_data)) begin
            int obs;
            obs = send_data ? E_SEND : int'(hs_code);
            if (exp_q.size() == 0) chk("unexpected reply", obs, E_NONE);
            else chk(tag_q.pop_front(), obs, exp_q.pop_front());
        end
    end

    task automatic expect_item(input int e, input string tag);
        if (e != E_NONE) begin
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
    endtask

    task automatic wr(input logic [9:0] v);
        @(negedge clk);
        sw_we = 1'b1;
        sw_wdata = v;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic rx_xact(input logic [1:0] kind, input int cnt, input bit crc,
                           input bit tog, input int e, input string tag,
                           input bit co_wr, input logic [9:0] co_val);
        expect_item(e, tag);
        @(negedge clk);
        tok_valid = 1'b1;
        tok_kind = kind;
        @(negedge clk);
        tok_valid = 1'b0;
        rx_done = 1'b1;
        rx_count = 7'(cnt);
        rx_crc_ok = crc;
        rx_toggle = tog;
        if (co_wr) begin
            sw_we = 1'b1;
            sw_wdata = co_val;
        end
        @(negedge clk);
        rx_done = 1'b0;
        sw_we = 1'b0;
        @(negedge clk);
        chk({tag, " queue drained"}, exp_q.size(), 0);
    endtask

    task automatic in_xact(input int e, input string tag, input bit ack);
        expect_item(e, tag);
        @(negedge clk);
        tok_valid = 1'b1;
        tok_kind = K_IN;
        @(negedge clk);
        tok_valid = 1'b0;
        @(negedge clk);
        host_ack = ack;
        @(negedge clk);
        host_ack = 1'b0;
        @(negedge clk);
        chk({tag, " queue drained"}, exp_q.size(), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk("watchdog", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset word", sw_rdata, 0);
        chk("R13 irq at reset", irq, 0);

        // R1/R11: write statuses; flag bits written as 1 stay clear
        wr(mk(0, 1, 1, 0, 0, 0, VAL, VAL));
        chk("R1 R11 write readback", sw_rdata, mk(0, 0, 0, 0, 0, 0, VAL, VAL));

        // R2: SETUP with valid status
        rx_xact(K_SETUP, 8, 1, 0, E_ACK, "R2 setup ack", 0, '0);
        chk("R2 setup state", sw_rdata, mk(1, 1, 0, 0, 0, 1, NAK, NAK));

        // R3: SETUP while receive flag pending
        rx_xact(K_SETUP, 8, 1, 0, E_NONE, "R3 setup silent", 0, '0);
        chk("R3 unchanged", sw_rdata, mk(1, 1, 0, 0, 0, 1, NAK, NAK));

        // R11: write 1 keeps flag, write 0 clears, seen bit ignores writes
        wr(mk(0, 1, 1, 0, 0, 1, STL, NAK));
        chk("R11 keep flag", sw_rdata, mk(1, 1, 0, 0, 0, 1, STL, NAK));
        wr(mk(0, 0, 1, 0, 0, 1, STL, NAK));
        chk("R11 clear flag", sw_rdata, mk(1, 0, 0, 0, 0, 1, STL, NAK));

        // R2: SETUP accepted despite stall
        rx_xact(K_SETUP, 8, 1, 1, E_ACK, "R2 setup over stall", 0, '0);
        chk("R2 state after stall", sw_rdata, mk(1, 1, 0, 0, 0, 1, NAK, NAK));

        // R4: OUT on nak / stall / disabled
        wr(mk(0, 0, 1, 0, 0, 1, NAK, NAK));
        rx_xact(K_OUT, 4, 1, 0, E_NAK, "R4 out nak", 0, '0);
        chk("R4 nak no change", sw_rdata, mk(1, 0, 0, 0, 0, 1, NAK, NAK));
        wr(mk(0, 0, 1, 0, 0, 1, STL, NAK));
        rx_xact(K_OUT, 4, 1, 0, E_STALL, "R4 out stall", 0, '0);
        chk("R4 stall no change", sw_rdata, mk(1, 0, 0, 0, 0, 1, STL, NAK));
        wr(mk(0, 0, 1, 0, 0, 1, DIS, NAK));
        rx_xact(K_OUT, 4, 1, 0, E_NONE, "R4 out disabled", 0, '0);
        chk("R4 disabled no change", sw_rdata, mk(1, 0, 0, 0, 0, 1, DIS, NAK));

        // R6: toggle mismatch
        wr(mk(0, 0, 1, 0, 0, 1, VAL, NAK));
        rx_xact(K_OUT, 8, 1, 1, E_ACK, "R6 mismatch ack", 0, '0);
        chk("R6 no change", sw_rdata, mk(1, 0, 0, 0, 0, 1, VAL, NAK));

        // R5: matching OUT
        rx_xact(K_OUT, 8, 1, 0, E_ACK, "R5 out ack", 0, '0);
        chk("R5 state", sw_rdata, mk(0, 1, 0, 0, 1, 1, NAK, NAK));
        chk("R13 irq rx flag", irq, 1);

        // R10: bad CRC
        wr(mk(0, 1, 1, 0, 1, 1, VAL, NAK));
        rx_xact(K_OUT, 8, 0, 1, E_NONE, "R10 bad crc", 0, '0);
        chk("R10 no change", sw_rdata, mk(0, 1, 0, 0, 1, 1, VAL, NAK));

        // R9: IN on nak
        in_xact(E_NAK, "R9 in nak", 0);
        chk("R9 nak no change", sw_rdata, mk(0, 1, 0, 0, 1, 1, VAL, NAK));

        // R8: IN valid with host ACK
        wr(mk(0, 0, 1, 0, 1, 1, VAL, VAL));
        chk("R8 toggle shown", tx_toggle, 1);
        in_xact(E_SEND, "R8 in send", 1);
        chk("R8 state", sw_rdata, mk(0, 0, 1, 0, 1, 0, VAL, NAK));
        chk("R13 irq tx flag", irq, 1);

        // R9: IN on stall and disabled
        wr(mk(0, 0, 1, 0, 1, 0, VAL, STL));
        in_xact(E_STALL, "R9 in stall", 0);
        wr(mk(0, 0, 1, 0, 1, 0, VAL, DIS));
        in_xact(E_NONE, "R9 in disabled", 1);
        chk("R9 disabled no change", sw_rdata, mk(0, 0, 1, 0, 1, 0, VAL, DIS));
        wr(mk(0, 0, 0, 0, 1, 0, VAL, DIS));
        chk("R13 irq clear", irq, 0);

        // R7: status-out kind
        wr(mk(0, 0, 0, 1, 1, 0, VAL, DIS));
        rx_xact(K_OUT, 5, 1, 1, E_STALL, "R7 nonempty stall", 0, '0);
        chk("R7 no flag", sw_rdata, mk(0, 0, 0, 1, 1, 0, VAL, DIS));
        rx_xact(K_OUT, 0, 1, 1, E_ACK, "R7 empty ack", 0, '0);
        chk("R7 empty state", sw_rdata, mk(0, 1, 0, 1, 0, 0, NAK, DIS));

        // R12: software write on the completing edge loses to hardware
        wr(mk(0, 0, 0, 0, 0, 0, VAL, DIS));
        rx_xact(K_OUT, 2, 1, 0, E_ACK, "R12 out ack", 1, mk(0, 0, 0, 0, 0, 0, VAL, DIS));
        chk("R12 hw wins", sw_rdata, mk(0, 1, 0, 0, 1, 0, NAK, DIS));

        // R3 again from an OUT-completed flag
        rx_xact(K_SETUP, 8, 1, 0, E_NONE, "R3 setup after out", 0, '0);
        chk("R3 unchanged after out", sw_rdata, mk(0, 1, 0, 0, 1, 0, NAK, DIS));

        repeat (3) @(negedge clk);
        chk("final queue empty", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule